// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block sits between a simple valid/ready command port and a byte-wide parallel EEPROM with a 17-bit address. A read command produces one byte on a result port. A write command either starts or extends a page burst. The block sequences write-enable-controlled byte loads into one 128-byte page and keeps the spacing and window limits that the device needs. It then waits for the device's internal program cycle to finish, either by watching the ready/busy pin or by waiting out the worst-case program time.

Every interval is a parameter in clock cycles. Its default is derived from a clock-frequency parameter, so a bench or an integrator can shrink or stretch all delays without touching the logic. The page is selected by address bits 16 to 7, and bits 6 to 0 select the byte within it. A burst therefore stays inside one page. Two sticky flags report a dropped off-page command and a program cycle that never finished.

Top module: `pee_ctrl`

## Requirements
- R1: While `rst` is high and for `RES_CYC` cycles after it falls, `ee_res_n` is low. `cmd_ready` stays low during that time and for at least `RP_CYC` further cycles with `ee_res_n` high.
- R2: A read drops `ee_ce_n` and `ee_oe_n` together. `rd_valid` pulses exactly `ACC_CYC`+1 cycles after the accepting clock edge, carrying the byte present on `ee_dq_in`. `ee_dq_oe` is never high while `ee_oe_n` is low.
- R3: Each byte load holds `ee_we_n` low for exactly `WP_CYC` cycles, with `ee_ce_n` low. Address and data stay constant while `ee_we_n` is low and remain driven for `DH_CYC` cycles after it rises.
- R4: Within a burst, consecutive `ee_we_n` falling edges are at least `SP_MIN_CYC` and at most `SP_MAX_CYC`-1 cycles apart.
- R5: Every falling edge of a burst lies within `BL_CYC`-1 cycles of its first one. Bytes that no longer fit wait and are loaded as a new burst after programming.
- R6: During a burst, a write whose address bits 16..7 differ from the burst's page, or any read, is consumed and dropped. That command sets `err_page`, which stays set until reset, and the burst closes.
- R7: The program phase begins `SP_MAX_CYC` cycles after the last byte's `ee_we_n` fall. `cmd_ready` stays low while the device reports busy (`ee_rdy` low) and until `DW_CYC` cycles after ready returns.
- R8: If `ee_rdy` does not return high within `WC_CYC` cycles of the program phase, the block returns to idle and sets `timeout_flag`, which stays set until reset.
- R9: Every byte of an accepted same-page write is presented on `ee_addr`/`ee_dq_out` at a write-enable rising edge, so the device ends up holding exactly the bytes written, in command order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted at this edge when valid |
| cmd_write | input | 1 | 1 = write byte, 0 = read byte |
| cmd_last | input | 1 | Write is the final byte of its burst |
| cmd_addr | input | 17 | Byte address; bits 16..7 are the page |
| cmd_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read data |
| err_page | output | 1 | Sticky: a command was dropped mid-burst |
| timeout_flag | output | 1 | Sticky: program cycle overran |
| ee_addr | output | 17 | Device address bus |
| ee_dq_out | output | 8 | Data toward device |
| ee_dq_oe | output | 1 | Drive enable for the data pads |
| ee_dq_in | input | 8 | Data from device |
| ee_ce_n | output | 1 | Chip enable, active low |
| ee_oe_n | output | 1 | Output enable, active low |
| ee_we_n | output | 1 | Write enable, active low |
| ee_res_n | output | 1 | Device reset, active low |
| ee_rdy | input | 1 | Device ready (1) / busy (0) |

## Verification
Each result has a fixed due cycle. Read data appears `ACC_CYC`+2 falling edges after the falling edge that precedes the accepting rising edge, and the bench requires that exact count. Device pins are registered from the next state, so a pin change is due one edge after the decision. The bench samples every output on the falling clock edge, where these values are stable. A device model in the bench latches data at write-enable rises and starts its busy period `SP_MAX_CYC` cycles after the last load. Spacing, window and pulse widths are measured from the observed pin edges and compared with the requirement bounds. The measurements do not depend on internal state.

// File: rtl/pee_pkg.sv
package pee_pkg;

  typedef enum logic [3:0] {
    S_RST_HOLD,
    S_RST_REC,
    S_IDLE,
    S_RD,
    S_RD_END,
    S_WE_LOW,
    S_WE_HOLD,
    S_GAP,
    S_PROG,
    S_RECOV
  } pee_state_e;

  // Round a duration in nanoseconds up to whole clock cycles, at least one.
  function automatic int ns_to_cyc(input longint ns, input int mhz);
    longint c;
    c = (ns * mhz + 999) / 1000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/pee_timer.sv
module pee_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pee_pace.sv
module pee_pace #(
  parameter int SP_MIN_CYC = 8,
  parameter int SP_MAX_CYC = 40,
  parameter int BL_CYC     = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic load,
  output logic load_ok,
  output logic expired
);

  localparam int LIM = (SP_MAX_CYC > BL_CYC) ? SP_MAX_CYC : BL_CYC;
  localparam int W   = $clog2(LIM + 2);
  localparam logic [W-1:0] L_MIN  = W'(SP_MIN_CYC - 1);
  localparam logic [W-1:0] L_MAX  = W'(SP_MAX_CYC - 2);
  localparam logic [W-1:0] L_EXP  = W'(SP_MAX_CYC - 1);
  localparam logic [W-1:0] L_WIN  = W'(BL_CYC - 2);

  logic [W-1:0] sp_cnt;
  logic [W-1:0] win_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_cnt  <= '0;
      win_cnt <= '0;
    end else begin
      if (start || load)    sp_cnt <= '0;
      else if (sp_cnt != '1) sp_cnt <= sp_cnt + 1'b1;
      if (start)              win_cnt <= '0;
      else if (win_cnt != '1) win_cnt <= win_cnt + 1'b1;
    end
  end

  always_comb begin
    load_ok = (sp_cnt >= L_MIN) && (sp_cnt <= L_MAX) && (win_cnt <= L_WIN);
    expired = (sp_cnt >= L_EXP);
  end

  AST_SPACE_FLOOR: assert property (@(posedge clk) disable iff (rst)
    load |=> (sp_cnt == '0) && ($past(sp_cnt) >= L_MIN)); // R4
  AST_WINDOW_CEIL: assert property (@(posedge clk) disable iff (rst)
    load |-> (win_cnt <= L_WIN)); // R5

endmodule

// File: rtl/pee_ctrl.sv
module pee_ctrl
  import pee_pkg::*;
#(
  parameter int CLK_MHZ    = 125,
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_LSB   = 7,
  parameter bit USE_RDY    = 1'b1,
  parameter int WP_CYC     = ns_to_cyc(250, CLK_MHZ) + 1,
  parameter int DH_CYC     = ns_to_cyc(10, CLK_MHZ) + 1,
  parameter int SP_MIN_CYC = ns_to_cyc(550, CLK_MHZ) + 1,
  parameter int SP_MAX_CYC = (30000 * CLK_MHZ) / 1000,
  parameter int BL_CYC     = (100000 * CLK_MHZ) / 1000,
  parameter int ACC_CYC    = ns_to_cyc(150, CLK_MHZ) + 1,
  parameter int DF_CYC     = ns_to_cyc(50, CLK_MHZ) + 1,
  parameter int DB_CYC     = ns_to_cyc(120, CLK_MHZ) + 3,
  parameter int DW_CYC     = ns_to_cyc(150, CLK_MHZ) + 1,
  parameter int WC_CYC     = ns_to_cyc(10000000, CLK_MHZ),
  parameter int RES_CYC    = ns_to_cyc(1000, CLK_MHZ),
  parameter int RP_CYC     = ns_to_cyc(100000, CLK_MHZ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_last,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_page,
  output logic              timeout_flag,
  output logic [ADDR_W-1:0] ee_addr,
  output logic [DATA_W-1:0] ee_dq_out,
  output logic              ee_dq_oe,
  input  logic [DATA_W-1:0] ee_dq_in,
  output logic              ee_ce_n,
  output logic              ee_oe_n,
  output logic              ee_we_n,
  output logic              ee_res_n,
  input  logic              ee_rdy
);

  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam int BIG    = (WC_CYC > RP_CYC) ? WC_CYC : RP_CYC;
  localparam int CNT_W  = $clog2(BIG + 2);

  pee_state_e        state, state_n;
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W-1:0] page_q;
  logic              burst_open;
  logic              rdy_s1, rdy_s2;
  logic              accept, same_page;
  logic              pace_start, pace_load, load_ok, expired;
  logic              rdy_seen, prog_over;

  pee_timer #(.W(CNT_W)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (state_n != state),
    .cnt (cnt)
  );

  pee_pace #(
    .SP_MIN_CYC (SP_MIN_CYC),
    .SP_MAX_CYC (SP_MAX_CYC),
    .BL_CYC     (BL_CYC)
  ) u_pace (
    .clk     (clk),
    .rst     (rst),
    .start   (pace_start),
    .load    (pace_load),
    .load_ok (load_ok),
    .expired (expired)
  );

  // two-stage synchronizer for the ready/busy pin
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_s1 <= 1'b0;
      rdy_s2 <= 1'b0;
    end else begin
      rdy_s1 <= ee_rdy;
      rdy_s2 <= rdy_s1;
    end
  end

  always_comb begin
    cmd_ready  = (state == S_IDLE) || ((state == S_GAP) && burst_open && load_ok);
    accept     = cmd_valid && cmd_ready;
    same_page  = (cmd_addr[ADDR_W-1:PAGE_LSB] == page_q);
    pace_start = accept && (state == S_IDLE) && cmd_write;
    pace_load  = accept && (state == S_GAP) && cmd_write && same_page;
    rdy_seen   = USE_RDY && (cnt >= CNT_W'(DB_CYC)) && rdy_s2;
    prog_over  = (cnt >= CNT_W'(WC_CYC - 1));
  end

  always_comb begin
    state_n = state;
    case (state)
      S_RST_HOLD: if (cnt >= CNT_W'(RES_CYC - 1)) state_n = S_RST_REC;
      S_RST_REC:  if (cnt >= CNT_W'(RP_CYC - 1))  state_n = S_IDLE;
      S_IDLE:     if (accept) state_n = cmd_write ? S_WE_LOW : S_RD;
      S_RD:       if (cnt >= CNT_W'(ACC_CYC))     state_n = S_RD_END;
      S_RD_END:   if (cnt >= CNT_W'(DF_CYC - 1))  state_n = S_IDLE;
      S_WE_LOW:   if (cnt >= CNT_W'(WP_CYC - 1))  state_n = S_WE_HOLD;
      S_WE_HOLD:  if (cnt >= CNT_W'(DH_CYC - 1))  state_n = S_GAP;
      S_GAP: begin
        if (pace_load)    state_n = S_WE_LOW;
        else if (expired) state_n = S_PROG;
      end
      S_PROG: begin
        if (rdy_seen)       state_n = S_RECOV;
        else if (prog_over) state_n = S_IDLE;
      end
      S_RECOV:    if (cnt >= CNT_W'(DW_CYC - 1))  state_n = S_IDLE;
      default:    state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_RST_HOLD;
      page_q       <= '0;
      burst_open   <= 1'b0;
      err_page     <= 1'b0;
      timeout_flag <= 1'b0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      ee_addr      <= '0;
      ee_dq_out    <= '0;
    end else begin
      state    <= state_n;
      rd_valid <= 1'b0;
      if (state == S_IDLE && accept) begin
        ee_addr   <= cmd_addr;
        ee_dq_out <= cmd_wdata;
        if (cmd_write) begin
          page_q     <= cmd_addr[ADDR_W-1:PAGE_LSB];
          burst_open <= !cmd_last;
        end
      end
      if (state == S_GAP && accept) begin
        if (pace_load) begin
          ee_addr    <= cmd_addr;
          ee_dq_out  <= cmd_wdata;
          burst_open <= !cmd_last;
        end else begin
          burst_open <= 1'b0;
          err_page   <= 1'b1;
        end
      end
      if (state == S_RD && state_n == S_RD_END) begin
        rd_valid <= 1'b1;
        rd_data  <= ee_dq_in;
      end
      if (state == S_PROG && !rdy_seen && prog_over && USE_RDY)
        timeout_flag <= 1'b1;
    end
  end

  // device pins follow the next state so they line up with the state register
  always_ff @(posedge clk) begin
    if (rst) begin
      ee_res_n <= 1'b0;
      ee_ce_n  <= 1'b1;
      ee_oe_n  <= 1'b1;
      ee_we_n  <= 1'b1;
      ee_dq_oe <= 1'b0;
    end else begin
      ee_res_n <= (state_n != S_RST_HOLD);
      ee_ce_n  <= !(state_n inside {S_RD, S_WE_LOW, S_WE_HOLD});
      ee_oe_n  <= (state_n != S_RD);
      ee_we_n  <= (state_n != S_WE_LOW);
      ee_dq_oe <= (state_n inside {S_WE_LOW, S_WE_HOLD});
    end
  end

  AST_RES_LOCKS_PORT: assert property (@(posedge clk) disable iff (rst)
    !ee_res_n |-> !cmd_ready); // R1
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !ee_oe_n |-> !ee_dq_oe); // R2
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !ee_we_n |-> (!ee_ce_n && ee_oe_n)); // R3
  AST_WE_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ee_we_n && $past(!ee_we_n)) |-> ($stable(ee_dq_out) && $stable(ee_addr))); // R3
  AST_PAGE_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(err_page) |-> err_page); // R6
  AST_NO_ACCEPT_IN_PROG: assert property (@(posedge clk) disable iff (rst)
    (state == S_PROG) |-> !cmd_ready); // R7
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(timeout_flag) |-> timeout_flag); // R8

endmodule

// File: tb/pee_ctrl_tb.sv
module pee_ctrl_tb;

  localparam int WP = 4, DH = 2, SPMIN = 10, SPMAX = 40, BL = 120;
  localparam int ACC = 3, DF = 2, DB = 5, DW = 3, WC = 300, RES = 4, RP = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_last = 1'b0;
  logic [16:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        cmd_ready, rd_valid, err_page, timeout_flag;
  logic [7:0]  rd_data, ee_dq_out, ee_dq_in;
  logic [16:0] ee_addr;
  logic        ee_dq_oe, ee_ce_n, ee_oe_n, ee_we_n, ee_res_n;
  logic        ee_rdy = 1'b1;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [7:0] dev_mem [0:1023];
  logic [7:0] exp_mem [0:1023];
  int  busy_cnt = 0, busy_len = 30, prog_count = 0;
  bit  pending = 0, we_prev = 1, kill_busy = 0, tmo_test = 0, done = 0;
  int  last_fall = 0, first_fall = 0, low_start = 0, dsp = 0;
  int  oe_viol = 0, rdy_viol = 0;

  always #4 clk = ~clk;

  pee_ctrl #(
    .WP_CYC(WP), .DH_CYC(DH), .SP_MIN_CYC(SPMIN), .SP_MAX_CYC(SPMAX), .BL_CYC(BL),
    .ACC_CYC(ACC), .DF_CYC(DF), .DB_CYC(DB), .DW_CYC(DW), .WC_CYC(WC),
    .RES_CYC(RES), .RP_CYC(RP)
  ) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_last(cmd_last), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_page(err_page), .timeout_flag(timeout_flag), .ee_addr(ee_addr),
    .ee_dq_out(ee_dq_out), .ee_dq_oe(ee_dq_oe), .ee_dq_in(ee_dq_in),
    .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n),
    .ee_res_n(ee_res_n), .ee_rdy(ee_rdy)
  );

  function automatic logic [7:0] init_byte(input int a);
    return 8'(a) ^ 8'h5A ^ {2'(a >> 8), 6'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  assign ee_dq_in = (!ee_ce_n && !ee_oe_n) ? dev_mem[ee_addr[9:0]] : 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  // device model and pin monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (we_prev && !ee_we_n) begin
        if (pending) begin
          chk((cyc - last_fall) >= SPMIN && (cyc - last_fall) <= SPMAX - 1,
              "R4 spacing", cyc - last_fall, SPMIN);
          chk((cyc - first_fall) <= BL - 1, "R5 window", cyc - first_fall, BL - 1);
        end else first_fall = cyc;
        last_fall = cyc; low_start = cyc; pending = 1; dsp = 0;
      end else dsp++;
      if (!we_prev && ee_we_n) begin
        chk((cyc - low_start) == WP, "R3 we width", cyc - low_start, WP);
        dev_mem[ee_addr[9:0]] = ee_dq_out;
      end
      if (pending && dsp == SPMAX) begin
        pending = 0; busy_cnt = busy_len; prog_count++;
      end else if (busy_cnt > 0) busy_cnt--;
      if (kill_busy) busy_cnt = 0;
      if (!ee_oe_n && ee_dq_oe) oe_viol++;
      if (busy_cnt > 0 && cmd_ready && !tmo_test) rdy_viol++;
      ee_rdy = (busy_cnt == 0);
      we_prev = ee_we_n;
    end
  end

  task automatic send(input bit w, input logic [16:0] a, input logic [7:0] d, input bit last);
    @(negedge clk);
    cmd_valid = 1; cmd_write = w; cmd_addr = a; cmd_wdata = d; cmd_last = last;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic rd_check(input logic [16:0] a);
    int k;
    send(0, a, 8'h00, 0);
    k = 1;
    while (!rd_valid && k < 60) begin @(negedge clk); k++; end
    chk(k == ACC + 2, "R2 read latency", k, ACC + 2);
    chk(rd_data == exp_mem[a[9:0]], "R9 read data", rd_data, exp_mem[a[9:0]]);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000 && !done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    int k, rh, p0, mism;
    logic [16:0] a;
    logic [7:0]  d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin
      dev_mem[i] = init_byte(i);
      exp_mem[i] = init_byte(i);
    end
    repeat (5) @(negedge clk);
    chk(ee_res_n == 0, "R1 reset pin low", ee_res_n, 0);
    chk(cmd_ready == 0, "R1 ready low in reset", cmd_ready, 0);
    rst = 0;
    k = 0; rh = 0;
    while (!cmd_ready && k < 1000) begin
      @(negedge clk); k++;
      if (ee_res_n && !cmd_ready) rh++;
    end
    chk(k >= RES + RP, "R1 recovery length", k, RES + RP);
    chk(rh >= RP, "R1 wait after reset high", rh, RP);
    chk(err_page == 0 && timeout_flag == 0, "R6 R8 flags clear", err_page, 0);

    // directed read of an unwritten byte
    rd_check(17'h00123);

    // random page bursts, each followed by a read-back
    for (int b = 0; b < 8; b++) begin
      int pg, len;
      pg  = $urandom % 8;
      len = 1 + $urandom % 6;
      for (int i = 0; i < len; i++) begin
        a = {10'(pg), 7'($urandom % 128)};
        d = 8'($urandom);
        exp_mem[a[9:0]] = d;
        send(1, a, d, i == len - 1);
      end
      rd_check(a);
      rd_check(17'($urandom % 1024));
    end
    chk(rdy_viol == 0, "R7 ready while busy", rdy_viol, 0);

    // off-page write inside a burst is dropped
    a = {10'd3, 7'd5};
    exp_mem[a[9:0]] = 8'hC3;
    send(1, a, 8'hC3, 0);
    send(1, {10'd4, 7'd5}, 8'h3C, 1);
    rd_check({10'd4, 7'd5});
    rd_check(a);
    chk(err_page == 1, "R6 page error flag", err_page, 1);

    // burst longer than the load window splits in two
    p0 = prog_count;
    for (int i = 0; i < 14; i++) begin
      a = {10'd5, 7'(i * 3)};
      d = 8'(8'h90 + i);
      exp_mem[a[9:0]] = d;
      send(1, a, d, i == 13);
    end
    rd_check({10'd5, 7'd39});
    chk(prog_count - p0 == 2, "R5 window split", prog_count - p0, 2);

    // program cycle that never finishes
    tmo_test = 1; busy_len = 100000;
    a = {10'd6, 7'd9};
    exp_mem[a[9:0]] = 8'h77;
    send(1, a, 8'h77, 1);
    k = 0;
    while (!cmd_ready && k < 2000) begin @(negedge clk); k++; end
    chk(timeout_flag == 1, "R8 timeout flag", timeout_flag, 1);
    chk(k >= WC, "R8 timeout wait", k, WC);
    kill_busy = 1; @(negedge clk); @(negedge clk); kill_busy = 0;
    busy_len = 30; tmo_test = 0;
    rd_check(a);
    chk(err_page == 1 && timeout_flag == 1, "R6 R8 flags sticky", err_page + timeout_flag, 2);

    mism = 0;
    for (int i = 0; i < 1024; i++) if (dev_mem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, "R9 device contents", mism, 0);
    chk(oe_viol == 0, "R2 bus released on read", oe_viol, 0);
    finish_run();
  end

endmodule